// File: doc/BRIEF.md
# Four-Channel Compare Match Timer

This block is a free-running system timer with four compare channels. A counter of 64 bits (or 32 bits, chosen by a parameter) advances on every edge of a slow timer clock. Software reaches the block through a plain register bus on a faster bus clock. It can read the counter as a low and a high word, program one 32-bit match value per channel, enable or disable each channel, and service per-channel match flags. Each flag also drives that channel's interrupt line.

Match values and enable bits are written in the bus domain and carried into the timer domain by a toggle handshake, one per field and channel. While a transfer is in flight, a pending-sync flag for that field reads as one. The usual way to arm a channel has three steps. Software writes the match value, then polls until that channel's match sync flag drops. In one write to the control word it then sets the channel's enable bit and writes a one to its match flag, which clears any stale event. When the low 32 bits of the counter become equal to the match value of an enabled channel, the flag and the interrupt rise and stay up until software clears them.

Register map, by word address: 0 is the control word, 1 the counter low word, 2 the counter high word, 3 reserved, and 4 to 7 the match values of channels 0 to 3. In the control word, bits 3:0 are the match flags, bits 7:4 the compare enables, bits 11:8 the enable sync flags and bits 15:12 the match sync flags. In each of these fields, bit n of the field belongs to channel n.

Top module: `mct_timer`

## Requirements
- R1: After reset the counter starts at zero and advances by one on every timer clock. Address 1 reads its low 32 bits, and address 2 reads its high 32 bits, which stay zero in 32-bit mode.
- R2: After reset the control word reads zero, all interrupts are low and all match registers read zero.
- R3: A write to address 4+n stores the match value of channel n, which reads back at that address. Control word bit 12+n reads one while the value is being carried into the timer domain and returns to zero when the transfer completes.
- R4: A write to a match register while its sync flag (bit 12+n) is set is discarded, and the earlier value stays in place.
- R5: Control word bit 4+n is the compare enable of channel n. A control-word write that changes it raises bit 8+n until the transfer completes, and a change written while bit 8+n is set is discarded.
- R6: When channel n is enabled and the low 32 bits of the counter become equal to its match value, flag bit n of the control word and irq[n] become one.
- R7: A channel whose enable bit is zero never sets its flag or its interrupt, even when its match value is reached.
- R8: Flag bits are write-one-to-clear through the control word. A zero written to a flag bit leaves that flag unchanged.
- R9: A set flag and its interrupt stay asserted until cleared, and one equality produces exactly one event. After a clear, the flag stays low while the counter moves past the match value.
- R10: Bits 31:16 of the control word and address 3 read zero, and bus writes to addresses 1, 2 and 3 change nothing.
- R11: Two enabled channels with the same match value set their flags and interrupts in the same bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| tmr_clk | input | 1 | Slow timer clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released into each domain through a synchronizer |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr, combinational |
| irq | output | 4 | Per-channel interrupt, equal to the match flags |

## Verification
Two channels can report a match on the same timer tick, and a flag clear can land in the same bus cycle in which another channel's event is being recorded. The bench programs channels 1 and 3 with one match value and arms both in a single control write. At the first bus sample where irq[1] is high it requires irq[3] to be high as well. It then writes a one to flag 1 only and checks that flag 3 and its interrupt survive the clear untouched, while flag 1 drops.

// File: rtl/mct_pkg.sv
package mct_pkg;

  localparam int unsigned NCH     = 4;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned MATCH_W = 32;

  // word addresses
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHI  = 3'd2;
  localparam int unsigned       A_MBASE = 4;

  // control word field offsets
  localparam int unsigned F_FLAG  = 0;
  localparam int unsigned F_EN    = 4;
  localparam int unsigned F_ESYNC = 8;
  localparam int unsigned F_MSYNC = 12;

  function automatic logic [63:0] bin2gray(input logic [63:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [63:0] gray2bin(input logic [63:0] g);
    logic [63:0] b;
    b[63] = g[63];
    for (int i = 62; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/mct_rst_sync.sv
module mct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/mct_bitsync.sv
module mct_bitsync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= {st_q[STAGES-2:0], d};
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/mct_xfer.sv
// Toggle handshake carrying one field from the bus domain to the timer domain.
module mct_xfer #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  output logic [W-1:0] src_q,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data
);

  // source side
  logic         req_q, req_nxt;
  logic [W-1:0] hold_q, hold_nxt;
  logic         ack_s;

  always_comb begin
    req_nxt  = req_q;
    hold_nxt = hold_q;
    if (src_load) begin
      req_nxt  = ~req_q;
      hold_nxt = src_data;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q  <= req_nxt;
      hold_q <= hold_nxt;
    end
  end

  // destination side
  logic         req_s, ack_q;
  logic [W-1:0] dat_q;
  logic         take;

  mct_bitsync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_q), .q(req_s)
  );

  assign take = req_s ^ ack_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else if (take) begin
      ack_q <= req_s;
      dat_q <= hold_q;
    end
  end

  mct_bitsync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(ack_q), .q(ack_s)
  );

  assign src_busy = req_q ^ ack_s;
  assign src_q    = hold_q;
  assign dst_data = dat_q;

  // R4/R5: the top must never start a transfer over one still in flight
  p_load_when_idle_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_load |-> !src_busy);

  // R3: a sync flag only rises because of an accepted write
  p_busy_from_load_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(src_busy) |-> $past(src_load));

  // R3: the captured value equals the held one while the request is served
  p_capture_match_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    take |=> dst_data == $past(hold_q));

endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter bit          WIDE        = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                bus_clk,
  input  logic                tmr_clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NCH-1:0]      irq
);

  localparam int unsigned CNT_W = WIDE ? 64 : 32;

  logic brst_n, trst_n;

  mct_rst_sync #(.STAGES(SYNC_STAGES)) u_brst (
    .clk(bus_clk), .arst_n(rst_n), .rst_n_o(brst_n)
  );
  mct_rst_sync #(.STAGES(SYNC_STAGES)) u_trst (
    .clk(tmr_clk), .arst_n(rst_n), .rst_n_o(trst_n)
  );

  // ---------------- timer domain ----------------
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic [63:0]        gray_q, gray_nxt;
  logic [NCH-1:0]     hit, evt_q, evt_nxt;
  logic [NCH-1:0]     en_t;
  logic [MATCH_W-1:0] match_t [NCH];

  always_comb begin
    cnt_nxt  = cnt_q + 1'b1;
    gray_nxt = bin2gray(64'(cnt_nxt));
    evt_nxt  = evt_q ^ hit;
  end

  always_ff @(posedge tmr_clk or negedge trst_n) begin
    if (!trst_n) begin
      cnt_q  <= '0;
      gray_q <= '0;
      evt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      gray_q <= gray_nxt;
      evt_q  <= evt_nxt;
    end
  end

  // ---------------- bus domain ----------------
  logic [63:0]        gray_s, cnt_rd;
  logic [NCH-1:0]     evt_s, evt_d, evt_pls;
  logic [NCH-1:0]     sts_q, sts_nxt, clr;
  logic [NCH-1:0]     en_q, e_busy, e_load;
  logic [NCH-1:0]     m_busy, m_load;
  logic [MATCH_W-1:0] match_q [NCH];
  logic               ctl_wr;

  mct_bitsync #(.W(64), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(bus_clk), .rst_n(brst_n), .d(gray_q), .q(gray_s)
  );
  mct_bitsync #(.W(NCH), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(bus_clk), .rst_n(brst_n), .d(evt_q), .q(evt_s)
  );

  always_comb begin
    cnt_rd  = gray2bin(gray_s);
    ctl_wr  = bus_wr && (bus_addr == A_CTL);
    clr     = ctl_wr ? bus_wdata[F_FLAG +: NCH] : '0;
    evt_pls = evt_s ^ evt_d;
    sts_nxt = (sts_q & ~clr) | evt_pls;   // a new event wins over a clear
  end

  always_ff @(posedge bus_clk or negedge brst_n) begin
    if (!brst_n) begin
      evt_d <= '0;
      sts_q <= '0;
    end else begin
      evt_d <= evt_s;
      sts_q <= sts_nxt;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign m_load[n] = bus_wr && (bus_addr == ADDR_W'(A_MBASE + n)) && !m_busy[n];
    assign e_load[n] = ctl_wr && (bus_wdata[F_EN+n] != en_q[n]) && !e_busy[n];

    mct_xfer #(.W(MATCH_W), .STAGES(SYNC_STAGES)) u_mxf (
      .src_clk(bus_clk), .src_rst_n(brst_n), .src_load(m_load[n]),
      .src_data(bus_wdata), .src_q(match_q[n]), .src_busy(m_busy[n]),
      .dst_clk(tmr_clk), .dst_rst_n(trst_n), .dst_data(match_t[n])
    );

    mct_xfer #(.W(1), .STAGES(SYNC_STAGES)) u_exf (
      .src_clk(bus_clk), .src_rst_n(brst_n), .src_load(e_load[n]),
      .src_data(bus_wdata[F_EN+n]), .src_q(en_q[n]), .src_busy(e_busy[n]),
      .dst_clk(tmr_clk), .dst_rst_n(trst_n), .dst_data(en_t[n])
    );

    assign hit[n] = en_t[n] && (cnt_q[MATCH_W-1:0] == match_t[n]);

    // R9: a flag holds until a one is written to it
    p_flag_sticky_r9: assert property (@(posedge bus_clk) disable iff (!brst_n)
      (sts_q[n] && !(ctl_wr && bus_wdata[F_FLAG+n])) |=> sts_q[n]);

    // R6: a flag rises only after an event crossed from the timer domain
    p_flag_from_event_r6: assert property (@(posedge bus_clk) disable iff (!brst_n)
      $rose(sts_q[n]) |-> $past(evt_pls[n]));

    // R3: an accepted match write shows as pending in the next cycle
    p_msync_raised_r3: assert property (@(posedge bus_clk) disable iff (!brst_n)
      m_load[n] |=> m_busy[n]);
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {16'h0, m_busy, e_busy, en_q, sts_q};
      A_CLO:   bus_rdata = cnt_rd[31:0];
      A_CHI:   bus_rdata = cnt_rd[63:32];
      3'd3:    bus_rdata = '0;
      default: bus_rdata = match_q[bus_addr[1:0]];
    endcase
  end

  assign irq = sts_q;

  // R1: the counter advances by exactly one per timer clock
  p_count_step_r1: assert property (@(posedge tmr_clk) disable iff (!trst_n)
    trst_n |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: tb/mct_timer_tb.sv
`timescale 1ns/1ps
module mct_timer_tb_top;

  logic        bus_clk = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        bus_wr  = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  always #2.5 bus_clk = ~bus_clk;   // 200 MHz
  always #6   tmr_clk = ~tmr_clk;   // slower timer domain

  mct_timer dut_i (
    .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    logic [31:0] mask;
    string       req;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [3:0] en_b = 4'h0;

  // monitor: pops one expectation per bus cycle and compares
  always @(posedge bus_clk) begin
    item_t it;
    logic [31:0] act;
    if (sbq.size() > 0) begin
      #1;
      it  = sbq.pop_front();
      act = it.is_irq ? {28'h0, irq} : bus_rdata;
      n_cmp++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h (mask %h)", it.req, act & it.mask,
                 it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic ctl_wr(input logic [3:0] clr);
    wr(3'd0, {24'h0, en_b, clr});
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e,
                           input logic [31:0] m, input string req);
    item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.mask = m; it.req = req;
    sbq.push_back(it);
    @(negedge bus_clk);
  endtask

  task automatic expect_irq(input logic [3:0] e, input string req);
    item_t it;
    it.is_irq = 1'b1; it.exp = {28'h0, e}; it.mask = 32'hF; it.req = req;
    sbq.push_back(it);
    @(negedge bus_clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge bus_clk); #1 v = bus_rdata;
    @(negedge bus_clk);
  endtask

  task automatic wait_clear(input logic [31:0] m, input string req);
    logic [31:0] v;
    bit ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      peek(3'd0, v);
      if ((v & m) == 0) begin ok = 1'b1; break; end
    end
    if (!ok) chk(1'b0, req, v & m, 32'h0);
  endtask

  task automatic wait_irq(input int idx, input string req, output logic [3:0] v);
    bit ok = 1'b0;
    v = 4'h0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge bus_clk); #1;
      if (irq[idx]) begin ok = 1'b1; v = irq; break; end
    end
    @(negedge bus_clk);
    if (!ok) chk(1'b0, req, {28'h0, irq}, 32'h1 << idx);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] c0, c1, c2, m;
    logic [3:0]  iv;
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge bus_clk);

    // R2: reset state
    expect_rd(3'd0, 32'h0, 32'hFFFF_FFFF, "R2 ctl word");
    expect_irq(4'h0, "R2 irq");
    for (int n = 0; n < 4; n++) expect_rd(3'(4 + n), 32'h0, 32'hFFFF_FFFF, "R2 match");
    // R10: reserved word
    expect_rd(3'd3, 32'h0, 32'hFFFF_FFFF, "R10 addr3");

    // R1: counting rate (241 bus cycles of 5 ns over a 12 ns tick ~ 100)
    peek(3'd1, c0);
    repeat (240) @(negedge bus_clk);
    peek(3'd1, c1);
    chk((c1 - c0) >= 97 && (c1 - c0) <= 104, "R1 count rate", c1 - c0, 32'd100);
    expect_rd(3'd2, 32'h0, 32'hFFFF_FFFF, "R1 high word");

    // R10: counter words are read-only
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    peek(3'd1, c2);
    chk(c2 >= c1 && c2 < 32'h1_0000, "R10 low word unchanged", c2, c1);
    expect_rd(3'd2, 32'h0, 32'hFFFF_FFFF, "R10 high word unchanged");
    expect_rd(3'd3, 32'h0, 32'hFFFF_FFFF, "R10 addr3 after write");

    // R3 / R4: match write, sync flag, discarded write while busy
    wr(3'd5, 32'hA5A5_0001);
    expect_rd(3'd0, 32'h1 << 13, 32'h1 << 13, "R3 msync set");
    wr(3'd5, 32'h0000_1234);
    wait_clear(32'h1 << 13, "R3 msync drop");
    expect_rd(3'd5, 32'hA5A5_0001, 32'hFFFF_FFFF, "R4 busy write discarded");
    expect_rd(3'd0, 32'h0, 32'hF000, "R3 msync idle");

    // R5: enable write, sync flag, discarded change while busy
    en_b[2] = 1'b1; ctl_wr(4'h0);
    expect_rd(3'd0, 32'h1 << 10, 32'h1 << 10, "R5 esync set");
    en_b[2] = 1'b0; ctl_wr(4'h0);
    en_b[2] = 1'b1;                       // the change above must be dropped
    wait_clear(32'h1 << 10, "R5 esync drop");
    expect_rd(3'd0, 32'h1 << 6, 32'h0000_0FF0, "R5 enable kept");
    en_b[2] = 1'b0; ctl_wr(4'h0);
    wait_clear(32'h1 << 10, "R5 esync drop 2");
    expect_rd(3'd0, 32'h0, 32'h0000_0FF0, "R5 enable cleared");

    // R6 / R7: ch0 enabled, ch2 disabled, both at the same value
    peek(3'd1, c0);
    m = c0 + 32'd300;
    wr(3'd4, m);
    wr(3'd6, m);
    wait_clear(32'h5 << 12, "R3 msync ch0/ch2");
    en_b[0] = 1'b1; ctl_wr(4'b0001);
    wait_clear(32'h1 << 8, "R5 esync ch0");
    expect_irq(4'h0, "R6 no early match");
    wait_irq(0, "R6 irq0 rises", iv);
    expect_irq(4'b0001, "R6 R7 only enabled channel fires");
    expect_rd(3'd0, 32'h1, 32'hF, "R6 flag0 set");
    peek(3'd1, c1);
    chk((c1 - m) <= 32'd12, "R6 match timing", c1 - m, 32'd3);

    // R9: sticky, then no re-fire after clear
    repeat (100) @(negedge bus_clk);
    expect_irq(4'b0001, "R9 flag held");
    ctl_wr(4'b0001);
    expect_irq(4'h0, "R8 clear flag0");
    repeat (200) @(negedge bus_clk);
    expect_irq(4'h0, "R9 no re-fire");

    // R11 / R8: two channels on one value, selective clear
    peek(3'd1, c0);
    m = c0 + 32'd300;
    wr(3'd5, m);
    wr(3'd7, m);
    wait_clear(32'hA << 12, "R3 msync ch1/ch3");
    en_b = 4'b1011; ctl_wr(4'b1010);
    wait_clear(32'hA << 8, "R5 esync ch1/ch3");
    wait_irq(1, "R11 irq1 rises", iv);
    chk(iv == 4'b1010, "R11 same-cycle flags", {28'h0, iv}, 32'hA);
    expect_irq(4'b1010, "R11 both held");
    ctl_wr(4'b0010);
    expect_irq(4'b1000, "R8 zero bits keep flag3");
    expect_rd(3'd0, 32'h0000_00B8, 32'hFFFF_FFFF, "R8 R10 ctl word");

    repeat (4) @(negedge bus_clk);
    finish_run();
  end

endmodule